// File: doc/BRIEF.md
# Banked GPIO Controller with Edge, Level and Wake Interrupts

This block is a memory-mapped controller for a parameterised number of general-purpose pins, arranged in banks of 32. Software reaches it over a plain register bus. It selects the direction of each pin and moves output latches high or low through dedicated write-1 registers. It reads back the conditioned input level of every pin.

Each input passes through a two-flop synchroniser and then through a per-pin glitch filter that can be bypassed. The conditioned value drives the event detection. Each pin can work in one of two modes. In edge mode it reacts to a rising edge, a falling edge, or both. In level mode it reacts to an active-high or an active-low level. A detected event is latched into two separate status vectors: one feeds the masked combined interrupt line, and the other feeds the masked wake line. Each status vector is cleared independently by writing ones to it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The register of a given kind for pin p sits at that kind's base + 4*(p/32), in bit p%32. The byte bases are as follows. Direction 0x01C. Input level 0x004. Output set 0x034 and output clear 0x04C. Rising enable 0x064 and falling enable 0x07C. Filter bypass 0x094. Interrupt enable 0x0AC and interrupt status 0x0C4. Mode select 0x300 and active-low select 0x318. Wake enable 0x330 and wake status 0x348.
- R2: A read of the input-level register returns the conditioned value of each pin. Bits above NUM_PINS read 0. Writes to this register have no effect.
- R3: A 1 written to an output-set bit drives that pin's output latch high, and a 1 written to an output-clear bit drives it low. A 0 bit leaves the pin unchanged, and no other write changes the latches. A read of either register returns the latch state.
- R4: A direction bit of 1 enables the pin's output driver (pad_oe), and a 0 makes the pin an input. Direction reads back as written, with bits above NUM_PINS reading 0.
- R5: With filter bypass 0, a synchronised input change reaches detection only after it has held for 3 consecutive clocks. Pulses of 2 clocks or less are dropped.
- R6: With filter bypass 1, the synchronised input goes straight to detection, so a single-clock pulse is seen.
- R7: In edge mode (mode bit 0), a rising edge latches status only if the rising enable is 1, and a falling edge latches status only if the falling enable is 1. Both enables may be set together.
- R8: In level mode (mode bit 1), status is latched while the pin is at its active level. The active level is high when the active-low bit is 0 and low when it is 1. Status is set again every clock while the pin stays active, so a clear has no lasting effect until the pin goes inactive.
- R9: Writing 1 to an interrupt status bit clears it, and bits written 0 keep their value.
- R10: irq is high exactly when some interrupt status bit and its interrupt enable bit are both 1.
- R11: Every event also sets the wake status bit, which is cleared by writing 1 independently of the interrupt status. wake is high when a set wake status bit has its wake enable bit set.
- R12: After reset, all control, latch and status registers are 0, and pad_out, pad_oe, irq and wake are low.
- R13: Address 0x000 and any address outside the listed windows read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_re | input | 1 | Read strobe; bus_rdata updates on the next clock edge |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pin inputs |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Output enables (direction) |
| irq | output | 1 | Combined masked interrupt |
| wake | output | 1 | Combined masked wake request |

## Verification
The assertions take for granted that bus_we, bus_addr and bus_wdata are known and word aligned whenever reset is released. They also assume that a write naming bank 0 bit 0 describes pin 0. Pin inputs are treated as asynchronous, so no property depends on when pad_in changes relative to the clock. The stimulus drives every bus and pad change on the falling clock edge, makes one access at a time at aligned addresses, and waits for at least six clocks after each pad change before it reads status, so the synchroniser and filter latency is always covered.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   localparam int BANK_BITS = 32;
   localparam int MAX_BANKS = 6;

   localparam logic [11:0] OFS_CFG   = 12'h000;
   localparam logic [11:0] OFS_LEVEL = 12'h004;
   localparam logic [11:0] OFS_DIR   = 12'h01C;
   localparam logic [11:0] OFS_SET   = 12'h034;
   localparam logic [11:0] OFS_CLR   = 12'h04C;
   localparam logic [11:0] OFS_RISE  = 12'h064;
   localparam logic [11:0] OFS_FALL  = 12'h07C;
   localparam logic [11:0] OFS_BYP   = 12'h094;
   localparam logic [11:0] OFS_MASK  = 12'h0AC;
   localparam logic [11:0] OFS_STAT  = 12'h0C4;
   localparam logic [11:0] OFS_TYPE  = 12'h300;
   localparam logic [11:0] OFS_POL   = 12'h318;
   localparam logic [11:0] OFS_WMASK = 12'h330;
   localparam logic [11:0] OFS_WSTAT = 12'h348;

   typedef enum logic [3:0] {
      RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_RISE, RK_FALL,
      RK_BYP, RK_MASK, RK_STAT, RK_TYPE, RK_POL, RK_WMASK, RK_WSTAT
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [2:0] bank;
   } reg_hit_t;

   function automatic logic in_window(input logic [11:0] a, input logic [11:0] base,
                                      input int nb);
      return (int'(a) >= int'(base)) && (int'(a) < int'(base) + 4 * nb) && (a[1:0] == 2'b00);
   endfunction

   function automatic logic [2:0] bank_of(input logic [11:0] a, input logic [11:0] base);
      logic [11:0] d;
      d = a - base;
      return d[4:2];
   endfunction

   function automatic reg_hit_t decode_addr(input logic [11:0] a, input int nb);
      reg_hit_t h;
      h.kind = RK_NONE;
      h.bank = '0;
      if      (in_window(a, OFS_LEVEL, nb)) begin h.kind = RK_LEVEL; h.bank = bank_of(a, OFS_LEVEL); end
      else if (in_window(a, OFS_DIR,   nb)) begin h.kind = RK_DIR;   h.bank = bank_of(a, OFS_DIR);   end
      else if (in_window(a, OFS_SET,   nb)) begin h.kind = RK_SET;   h.bank = bank_of(a, OFS_SET);   end
      else if (in_window(a, OFS_CLR,   nb)) begin h.kind = RK_CLR;   h.bank = bank_of(a, OFS_CLR);   end
      else if (in_window(a, OFS_RISE,  nb)) begin h.kind = RK_RISE;  h.bank = bank_of(a, OFS_RISE);  end
      else if (in_window(a, OFS_FALL,  nb)) begin h.kind = RK_FALL;  h.bank = bank_of(a, OFS_FALL);  end
      else if (in_window(a, OFS_BYP,   nb)) begin h.kind = RK_BYP;   h.bank = bank_of(a, OFS_BYP);   end
      else if (in_window(a, OFS_MASK,  nb)) begin h.kind = RK_MASK;  h.bank = bank_of(a, OFS_MASK);  end
      else if (in_window(a, OFS_STAT,  nb)) begin h.kind = RK_STAT;  h.bank = bank_of(a, OFS_STAT);  end
      else if (in_window(a, OFS_TYPE,  nb)) begin h.kind = RK_TYPE;  h.bank = bank_of(a, OFS_TYPE);  end
      else if (in_window(a, OFS_POL,   nb)) begin h.kind = RK_POL;   h.bank = bank_of(a, OFS_POL);   end
      else if (in_window(a, OFS_WMASK, nb)) begin h.kind = RK_WMASK; h.bank = bank_of(a, OFS_WMASK); end
      else if (in_window(a, OFS_WSTAT, nb)) begin h.kind = RK_WSTAT; h.bank = bank_of(a, OFS_WSTAT); end
      return h;
   endfunction

endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad,
   input  logic [W-1:0] bypass,
   output logic [W-1:0] clean
);

   logic [W-1:0] sync_q [SYNC_STAGES];
   logic [W-1:0] synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      end else begin
         sync_q[0] <= pad;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         // Filter disabled at build time: the bypass bits select nothing.
         assign clean = synced | (bypass & ~bypass);
      end else begin : g_filt
         localparam int CW = $clog2(FILT_LEN);
         for (genvar p = 0; p < W; p++) begin : g_pin
            logic [CW-1:0] run_q;
            logic          held_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  run_q  <= '0;
                  held_q <= 1'b0;
               end else if (synced[p] == held_q) begin
                  run_q <= '0;
               end else if (run_q == CW'(FILT_LEN - 1)) begin
                  run_q  <= '0;
                  held_q <= synced[p];
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
            assign clean[p] = bypass[p] ? synced[p] : held_q;
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] clean,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] lvl_mode,
   input  logic [W-1:0] lvl_low,
   output logic [W-1:0] evt
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, lvl_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= clean;
   end

   assign rise    = clean & ~prev_q;
   assign fall    = ~clean & prev_q;
   assign lvl_act = clean ^ lvl_low;
   assign evt     = (lvl_mode & lvl_act) | (~lvl_mode & ((rise & rise_en) | (fall & fall_en)));

endmodule

// File: rtl/gpio_w1c_status.sv
module gpio_w1c_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] en,
   output logic [W-1:0] st,
   output logic         any
);

   // A new event in the same cycle as a clear wins, so an active level keeps its bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= (st & ~clr) | evt;
   end

   assign any = |(st & en);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int NUM_PINS    = 40,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic                bus_re,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq,
   output logic                wake
);

   localparam int NBANK = (NUM_PINS + BANK_BITS - 1) / BANK_BITS;
   localparam int W     = NBANK * BANK_BITS;
   localparam logic [W-1:0] PIN_MASK = {W{1'b1}} >> (W - NUM_PINS);

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_BANKS * BANK_BITS) begin : g_bad_pins
         $error("NUM_PINS out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   reg_hit_t     hit;
   logic [W-1:0] wr_vec, sel_vec, wbits;
   logic [W-1:0] dir_q, out_q, rise_q, fall_q, byp_q, mask_q, type_q, pol_q, wmask_q;
   logic [W-1:0] pad_w, clean_w, evt_w, irq_st, wake_st, stat_clr, wake_clr;
   logic [W-1:0] rd_src;
   logic [31:0]  rd_word;

   assign hit = decode_addr(bus_addr, NBANK);

   always_comb begin
      for (int b = 0; b < NBANK; b++) begin
         wr_vec[b*BANK_BITS +: BANK_BITS]  = bus_wdata;
         sel_vec[b*BANK_BITS +: BANK_BITS] = (int'(hit.bank) == b) ? '1 : '0;
      end
   end

   assign wbits    = wr_vec & sel_vec & PIN_MASK;
   assign stat_clr = (bus_we && hit.kind == RK_STAT)  ? wbits : '0;
   assign wake_clr = (bus_we && hit.kind == RK_WSTAT) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         out_q   <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         byp_q   <= '0;
         mask_q  <= '0;
         type_q  <= '0;
         pol_q   <= '0;
         wmask_q <= '0;
      end else if (bus_we) begin
         unique case (hit.kind)
            RK_DIR:   dir_q   <= (dir_q   & ~sel_vec) | wbits;
            RK_SET:   out_q   <= out_q | wbits;
            RK_CLR:   out_q   <= out_q & ~wbits;
            RK_RISE:  rise_q  <= (rise_q  & ~sel_vec) | wbits;
            RK_FALL:  fall_q  <= (fall_q  & ~sel_vec) | wbits;
            RK_BYP:   byp_q   <= (byp_q   & ~sel_vec) | wbits;
            RK_MASK:  mask_q  <= (mask_q  & ~sel_vec) | wbits;
            RK_TYPE:  type_q  <= (type_q  & ~sel_vec) | wbits;
            RK_POL:   pol_q   <= (pol_q   & ~sel_vec) | wbits;
            RK_WMASK: wmask_q <= (wmask_q & ~sel_vec) | wbits;
            default: ;
         endcase
      end
   end

   assign pad_w   = W'(pad_in);
   assign pad_out = out_q[NUM_PINS-1:0];
   assign pad_oe  = dir_q[NUM_PINS-1:0];

   gpio_in_cond #(.W(W), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad    (pad_w),
      .bypass (byp_q),
      .clean  (clean_w)
   );

   gpio_evt_detect #(.W(W)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clean    (clean_w),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .lvl_mode (type_q),
      .lvl_low  (pol_q),
      .evt      (evt_w)
   );

   gpio_w1c_status #(.W(W)) u_irq_st (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_w),
      .clr   (stat_clr),
      .en    (mask_q),
      .st    (irq_st),
      .any   (irq)
   );

   gpio_w1c_status #(.W(W)) u_wake_st (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_w),
      .clr   (wake_clr),
      .en    (wmask_q),
      .st    (wake_st),
      .any   (wake)
   );

   always_comb begin
      unique case (hit.kind)
         RK_LEVEL: rd_src = clean_w & PIN_MASK;
         RK_DIR:   rd_src = dir_q;
         RK_SET,
         RK_CLR:   rd_src = out_q;
         RK_RISE:  rd_src = rise_q;
         RK_FALL:  rd_src = fall_q;
         RK_BYP:   rd_src = byp_q;
         RK_MASK:  rd_src = mask_q;
         RK_STAT:  rd_src = irq_st;
         RK_TYPE:  rd_src = type_q;
         RK_POL:   rd_src = pol_q;
         RK_WMASK: rd_src = wmask_q;
         RK_WSTAT: rd_src = wake_st;
         default:  rd_src = '0;
      endcase
   end

   assign rd_word = rd_src[int'(hit.bank)*BANK_BITS +: BANK_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_word;
   end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
   import gpio_ctrl_pkg::*;
#(
   parameter int NUM_PINS = 40,
   parameter int W        = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [11:0]         bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq,
   input logic                evt0,
   input logic                irq_st0,
   input logic                wake_st0,
   input logic [W-1:0]        mask_bits
);

   localparam int NB = W / BANK_BITS;

   logic touches_out;
   assign touches_out = bus_we && (in_window(bus_addr, OFS_SET, NB) || in_window(bus_addr, OFS_CLR, NB));

   assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_SET && bus_wdata[0]) |=> pad_out[0]);

   assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_CLR && bus_wdata[0]) |=> !pad_out[0]);

   assert_out_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !touches_out |=> $stable(pad_out));

   assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DIR) |=> pad_oe[0] == $past(bus_wdata[0]));

   assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_bits == '0) |-> !irq);

   assert_event_latches_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
      evt0 |=> (irq_st0 && wake_st0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .evt0      (evt_w[0]),
   .irq_st0   (irq_st[0]),
   .wake_st0  (wake_st[0]),
   .mask_bits (mask_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
   import gpio_ctrl_pkg::*;

   localparam int N = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_re = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe;
   logic          irq, wake;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   gpio_bank_ctrl u_dut (
      .clk, .rst_n, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata,
      .pad_in, .pad_out, .pad_oe, .irq, .wake
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] r;
      logic [N-1:0] exp_out;
      logic [N-1:0] pat;
      logic ren, fen;
      exp_out = '0;

      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R12 reset state
      chk("R12 pad_out", 64'(pad_out), 64'h0);
      chk("R12 pad_oe", 64'(pad_oe), 64'h0);
      chk("R12 irq", 64'(irq), 64'h0);
      chk("R12 wake", 64'(wake), 64'h0);
      rd(OFS_MASK, r);   chk("R12 mask reads 0", 64'(r), 64'h0);
      rd(OFS_DIR + 4, r); chk("R12 dir bank1 reads 0", 64'(r), 64'h0);

      // R4 direction
      wr(OFS_DIR, 32'hA5A5_0F0F);
      wr(OFS_DIR + 4, 32'hFFFF_FFFF);
      chk("R4 pad_oe", 64'(pad_oe), 64'h00FF_A5A5_0F0F);
      rd(OFS_DIR + 4, r); chk("R4 dir bank1 unused bits 0", 64'(r), 64'h0000_00FF);
      rd(OFS_DIR, r);     chk("R4 dir bank0 readback", 64'(r), 64'hA5A5_0F0F);

      // R3 / R1 set sweep over every pin, then clear the even pins
      for (int p = 0; p < N; p++) begin
         wr(OFS_SET + 12'(4 * (p / 32)), 32'(1) << (p % 32));
         exp_out[p] = 1'b1;
         chk("R3 R1 set sweep", 64'(pad_out), 64'(exp_out));
      end
      for (int p = 0; p < N; p += 2) begin
         wr(OFS_CLR + 12'(4 * (p / 32)), 32'(1) << (p % 32));
         exp_out[p] = 1'b0;
         chk("R3 R1 clear sweep", 64'(pad_out), 64'(exp_out));
      end
      wr(OFS_SET, 32'h0);
      wr(OFS_CLR + 4, 32'h0);
      chk("R3 zero bits leave latch", 64'(pad_out), 64'(exp_out));
      rd(OFS_SET, r);     chk("R3 set readback", 64'(r), 64'(exp_out[31:0]));
      rd(OFS_CLR + 4, r); chk("R3 clear readback bank1", 64'(r), 64'(exp_out[N-1:32]));

      // R13 unmapped and config space
      rd(OFS_CFG, r);  chk("R13 config reads 0", 64'(r), 64'h0);
      rd(12'h200, r);  chk("R13 hole reads 0", 64'(r), 64'h0);
      wr(OFS_CFG, 32'hFFFF_FFFF);
      wr(12'h200, 32'hFFFF_FFFF);
      wr(OFS_WSTAT + 12'h18, 32'hFFFF_FFFF);
      chk("R13 writes ignored (out)", 64'(pad_out), 64'(exp_out));
      chk("R13 writes ignored (oe)", 64'(pad_oe), 64'h00FF_A5A5_0F0F);

      // R2 level readback, bypassed then filtered
      wr(OFS_BYP, 32'hFFFF_FFFF);
      wr(OFS_BYP + 4, 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
         pat = (N'(1) << (k * 7)) ^ {5{8'(k * 37 + 5)}};
         @(negedge clk); pad_in = pat;
         idle(4);
         rd(OFS_LEVEL, r);     chk("R2 level bank0 bypass", 64'(r), 64'(pat[31:0]));
         rd(OFS_LEVEL + 4, r); chk("R2 level bank1 bypass", 64'(r), 64'(pat[N-1:32]));
      end
      wr(OFS_BYP, 32'h0);
      wr(OFS_BYP + 4, 32'h0);
      for (int k = 0; k < 4; k++) begin
         pat = ~((N'(3) << (k * 9)) ^ {5{8'(k * 91)}});
         @(negedge clk); pad_in = pat;
         idle(8);
         rd(OFS_LEVEL, r);     chk("R2 level bank0 filtered", 64'(r), 64'(pat[31:0]));
         rd(OFS_LEVEL + 4, r); chk("R2 level bank1 filtered", 64'(r), 64'(pat[N-1:32]));
      end
      wr(OFS_LEVEL, 32'h0);
      rd(OFS_LEVEL, r); chk("R2 level write ignored", 64'(r), 64'(pat[31:0]));
      @(negedge clk); pad_in = '0;
      idle(10);

      // R5 glitch filter on pin 0
      wr(OFS_RISE, 32'h1);
      wr(OFS_MASK, 32'h1);
      wr(OFS_STAT, 32'hFFFF_FFFF);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(2); pad_in[0] = 1'b0;
      idle(10);
      rd(OFS_STAT, r); chk("R5 2-clock pulse dropped", 64'(r[0]), 64'h0);
      chk("R5 irq stays low", 64'(irq), 64'h0);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(3); pad_in[0] = 1'b0;
      idle(10);
      rd(OFS_STAT, r); chk("R5 3-clock pulse passes", 64'(r[0]), 64'h1);
      chk("R10 irq with enable", 64'(irq), 64'h1);

      // R9 clear
      wr(OFS_STAT, 32'h1);
      rd(OFS_STAT, r); chk("R9 w1c clears", 64'(r[0]), 64'h0);
      chk("R10 irq drops", 64'(irq), 64'h0);

      // R6 bypass passes one-clock pulse
      wr(OFS_BYP, 32'h7);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(1); pad_in[0] = 1'b0;
      idle(6);
      rd(OFS_STAT, r); chk("R6 1-clock pulse seen", 64'(r[0]), 64'h1);
      wr(OFS_STAT, 32'h1);
      wr(OFS_MASK, 32'h0);

      // R7 all enable combinations on pin 1
      for (int c = 0; c < 4; c++) begin
         ren = c[0]; fen = c[1];
         wr(OFS_RISE, 32'(ren) << 1);
         wr(OFS_FALL, 32'(fen) << 1);
         wr(OFS_STAT, 32'hFFFF_FFFF);
         @(negedge clk); pad_in[1] = 1'b1;
         idle(6);
         rd(OFS_STAT, r); chk("R7 rising edge", 64'(r[1]), 64'(ren));
         wr(OFS_STAT, 32'h2);
         @(negedge clk); pad_in[1] = 1'b0;
         idle(6);
         rd(OFS_STAT, r); chk("R7 falling edge", 64'(r[1]), 64'(fen));
      end
      wr(OFS_RISE, 32'h0);
      wr(OFS_FALL, 32'h0);
      wr(OFS_STAT, 32'hFFFF_FFFF);

      // R8 level mode on pin 2
      wr(OFS_POL, 32'h0);
      wr(OFS_TYPE, 32'h4);
      idle(2);
      rd(OFS_STAT, r); chk("R8 inactive low level", 64'(r[2]), 64'h0);
      @(negedge clk); pad_in[2] = 1'b1;
      idle(6);
      rd(OFS_STAT, r); chk("R8 active high", 64'(r[2]), 64'h1);
      wr(OFS_STAT, 32'h4);
      rd(OFS_STAT, r); chk("R8 re-set while active", 64'(r[2]), 64'h1);
      @(negedge clk); pad_in[2] = 1'b0;
      idle(6);
      wr(OFS_STAT, 32'h4);
      rd(OFS_STAT, r); chk("R8 clears once inactive", 64'(r[2]), 64'h0);
      wr(OFS_POL, 32'h4);
      idle(2);
      rd(OFS_STAT, r); chk("R8 active low", 64'(r[2]), 64'h1);
      @(negedge clk); pad_in[2] = 1'b1;
      idle(6);
      wr(OFS_STAT, 32'h4);
      rd(OFS_STAT, r); chk("R8 high inactive when active-low", 64'(r[2]), 64'h0);
      wr(OFS_TYPE, 32'h0);
      wr(OFS_POL, 32'h0);
      wr(OFS_STAT, 32'hFFFF_FFFF);
      wr(OFS_WSTAT, 32'hFFFF_FFFF);
      wr(OFS_WSTAT + 4, 32'hFFFF_FFFF);

      // R10 / R11 on pin 1
      wr(OFS_RISE, 32'h2);
      @(negedge clk); pad_in[1] = 1'b1;
      idle(6);
      chk("R10 masked status keeps irq low", 64'(irq), 64'h0);
      wr(OFS_MASK, 32'h2);
      chk("R10 enable raises irq", 64'(irq), 64'h1);
      rd(OFS_WSTAT, r); chk("R11 wake status latched", 64'(r[1]), 64'h1);
      chk("R11 wake masked", 64'(wake), 64'h0);
      wr(OFS_WMASK, 32'h2);
      chk("R11 wake enabled", 64'(wake), 64'h1);
      wr(OFS_WSTAT, 32'h2);
      chk("R11 wake cleared", 64'(wake), 64'h0);
      rd(OFS_STAT, r); chk("R11 irq status independent", 64'(r[1]), 64'h1);
      chk("R10 irq still high", 64'(irq), 64'h1);

      // R9 zero bits untouched
      wr(OFS_RISE, 32'h3);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(6);
      rd(OFS_STAT, r); chk("R9 two pending", 64'(r[1:0]), 64'h3);
      wr(OFS_STAT, 32'h1);
      rd(OFS_STAT, r); chk("R9 zero bit kept", 64'(r[1:0]), 64'h2);

      // R1 bank 1 pin 35
      wr(OFS_BYP + 4, 32'h8);
      wr(OFS_RISE + 4, 32'h8);
      wr(OFS_MASK, 32'h0);
      @(negedge clk); pad_in[35] = 1'b1;
      idle(6);
      rd(OFS_STAT + 4, r); chk("R1 bank1 bit3 status", 64'(r), 64'h8);
      chk("R10 no enable for pin 35", 64'(irq), 64'h0);
      wr(OFS_MASK + 4, 32'h8);
      chk("R10 pin 35 enable", 64'(irq), 64'h1);

      summary();
   end

endmodule